// File: doc/BRIEF.md
# I2C Target with 7-bit and 10-bit Addressing

This block is the bus side of an I2C target. It samples the SCL and SDA lines with the system clock through a two-flop synchroniser and recognises start, repeated start and stop conditions from the synchronised levels. It drives the bus only through open-drain pull-down enables: one for SDA and, when stretching is built in, one for SCL.

After every start the target decodes the first frame. A plain 7-bit address is compared with its own 7-bit address. A frame that begins with the 11110 prefix opens a two-frame 10-bit address. The target acknowledges that header when the two high address bits in it match. It then acknowledges the second frame only when the low eight bits match as well. Once addressed, the target serves a small internal register file. In a write, the first data byte selects the register pointer and each later byte is stored at the pointer. In a read, bytes come from the pointer onward. The pointer advances after every data byte. A repeated start restarts address decoding, which allows a pointer write followed by a read. While the local stall input is high, an addressed target holds SCL low.

Top module: `i2c_tgt10`

## Requirements
- R1: After reset both pull-down enables are released, the pointer is 0, and register i holds 0xA0 + i.
- R2: A first frame whose upper 7 bits (bits 7..1) equal OWN_ADDR7 is acknowledged by pulling SDA low during the 9th clock. Frame bit 0 selects the direction: 1 = read, 0 = write. Any other non-11110 frame is not acknowledged, and the target ignores the bus until the next start.
- R3: A first frame of the form 11110 h1 h0 d (bits 7..3 = 11110) is acknowledged when h1 h0 equal OWN_ADDR10[9:8]; otherwise it is not acknowledged and the bus is ignored until the next start. Bit d is the direction for the transfer that follows.
- R4: After an acknowledged 10-bit header, the next frame is acknowledged only if it equals OWN_ADDR10[7:0]. On a mismatch SDA stays released and the bus is ignored until the next start.
- R5: In a write every data byte is acknowledged. The first data byte after the address loads the pointer from its low log2(NUM_REGS) bits. Each later byte is stored at the pointer, and the pointer then advances, wrapping modulo NUM_REGS.
- R6: In a read the target shifts out the register at the current pointer MSB first, one bit per SCL low phase, starting in the low phase after the address acknowledge. The pointer advances after each byte, and the next read transfer continues from there.
- R7: A controller NACK after a read byte makes the target release SDA and ignore all further clocks until the next start or stop.
- R8: A repeated start, without an intervening stop, restarts address decoding, so a pointer write followed by a read returns the registers written earlier.
- R9: A stop releases SDA and returns the target to idle.
- R10: With STRETCH_EN set, an addressed target pulls SCL low while stall_i is high, asserting it only while SCL is low. It releases SCL one cycle after stall_i falls and never stretches while idle.
- R11: The target changes its SDA drive only while SCL is low. The one exception is the release forced by a start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for sampling and all state |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| stall_i | input | 1 | Local request to hold SCL low |
| sda_pull_o | output | 1 | Pull SDA low when 1 (open-drain enable) |
| scl_pull_o | output | 1 | Pull SCL low when 1 (open-drain enable) |

## Verification
A raw SCL fall reaches the synchronised view two cycles later. The edge is detected there, and the new SDA drive appears at the third clock edge after the raw fall. The SCL pull-down follows a change of stall_i by one cycle once SCL is seen low. The bench's controller model waits ten system cycles per quarter SCL period before it moves a line or samples one. Every acknowledge, data bit and stretch level is therefore read well after it is due and well before the next bus change. Register contents and the pointer are only observed through later read transfers, and expected values come from a bench-side register model.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_LO,
    ST_WR,
    ST_RD
  } tgt_state_e;

  localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

  // Header frame of a two-frame address
  function automatic logic is_ten_hdr(input logic [7:0] frame);
    return frame[7:3] == TEN_BIT_TAG;
  endfunction

  // Reset content of register idx
  function automatic logic [7:0] reg_reset_val(input int unsigned idx);
    return 8'hA0 + 8'(idx);
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_tgt_match.sv
module i2c_tgt_match
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR7  = 7'h2A,
  parameter logic [9:0] OWN_ADDR10 = 10'h2C5
) (
  input  logic [7:0] frame,
  input  logic       lo_phase,
  output logic       ten_hdr,
  output logic       hit
);
  assign ten_hdr = is_ten_hdr(frame);

  always_comb begin
    if (lo_phase)     hit = (frame == OWN_ADDR10[7:0]);
    else if (ten_hdr) hit = (frame[2:1] == OWN_ADDR10[9:8]);
    else              hit = (frame[7:1] == OWN_ADDR7);
  end
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int PTR_W    = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [PTR_W-1:0] raddr,
  output logic [7:0]       rdata
);
  logic [7:0] rd_vec [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= reg_reset_val(g);
      else if (we && waddr == PTR_W'(g))   q <= wdata;
    end
    assign rd_vec[g] = q;
  end

  assign rdata = rd_vec[raddr];
endmodule

// File: rtl/i2c_tgt10.sv
module i2c_tgt10
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR7   = 7'h2A,
  parameter logic [9:0] OWN_ADDR10  = 10'h2C5,
  parameter int         NUM_REGS    = 8,
  parameter bit         STRETCH_EN  = 1'b1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic stall_i,
  output logic sda_pull_o,
  output logic scl_pull_o
);
  localparam int PTR_W = $clog2(NUM_REGS);

  // synchronised bus view and line events
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tgt_state_e       state_q, nxt_q;
  logic [3:0]       bitcnt_q;
  logic [6:0]       shreg_q;
  logic [6:0]       txreg_q;
  logic             ack_q, rw_q, ptr_pend_q, sda_pull_q;
  logic [PTR_W-1:0] ptr_q;

  // named internal events
  logic [7:0] rx_frame;
  logic       rx_state, byte_done, frame_hit, ten_hdr, frame_ok;
  logic       reg_we, ack_sample, in_idle, addressed;
  logic [7:0] rd_data;

  assign rx_frame   = {shreg_q, sda_s};
  assign rx_state   = (state_q == ST_HDR) || (state_q == ST_LO) || (state_q == ST_WR);
  assign byte_done  = rx_state && scl_rise && (bitcnt_q == 4'd7);
  assign frame_ok   = (state_q == ST_WR) ? 1'b1 : frame_hit;
  assign reg_we     = byte_done && (state_q == ST_WR) && !ptr_pend_q;
  assign ack_sample = (state_q == ST_RD) && scl_rise && (bitcnt_q == 4'd8);
  assign in_idle    = (state_q == ST_IDLE);
  assign addressed  = (state_q == ST_WR) || (state_q == ST_RD);

  i2c_tgt_match #(.OWN_ADDR7(OWN_ADDR7), .OWN_ADDR10(OWN_ADDR10)) u_match (
    .frame(rx_frame), .lo_phase(state_q == ST_LO), .ten_hdr(ten_hdr), .hit(frame_hit)
  );

  i2c_tgt_regs #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(ptr_q), .wdata(rx_frame),
    .raddr(ptr_q), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      nxt_q      <= ST_IDLE;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      txreg_q    <= '0;
      ack_q      <= 1'b0;
      rw_q       <= 1'b0;
      ptr_pend_q <= 1'b0;
      sda_pull_q <= 1'b0;
      ptr_q      <= '0;
    end else if (start_det) begin
      state_q    <= ST_HDR;
      bitcnt_q   <= '0;
      sda_pull_q <= 1'b0;
    end else if (stop_det) begin
      state_q    <= ST_IDLE;
      sda_pull_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_HDR, ST_LO, ST_WR: begin
          if (scl_rise) begin
            bitcnt_q <= bitcnt_q + 4'd1;
            if (bitcnt_q < 4'd8) shreg_q <= rx_frame[6:0];
            if (byte_done) begin
              ack_q <= frame_ok;
              if (!frame_ok) state_q <= ST_IDLE;
              if (state_q == ST_HDR) begin
                if (ten_hdr) begin
                  nxt_q <= ST_LO;
                  rw_q  <= rx_frame[0];
                end else begin
                  nxt_q      <= rx_frame[0] ? ST_RD : ST_WR;
                  ptr_pend_q <= !rx_frame[0];
                end
              end else if (state_q == ST_LO) begin
                nxt_q      <= rw_q ? ST_RD : ST_WR;
                ptr_pend_q <= !rw_q;
              end else begin
                nxt_q <= ST_WR;
                if (ptr_pend_q) begin
                  ptr_q      <= rx_frame[PTR_W-1:0];
                  ptr_pend_q <= 1'b0;
                end else begin
                  ptr_q <= ptr_q + PTR_W'(1);
                end
              end
            end
          end
          if (scl_fall) begin
            if (bitcnt_q == 4'd8) begin
              sda_pull_q <= ack_q;
            end else if (bitcnt_q == 4'd9) begin
              bitcnt_q <= '0;
              state_q  <= nxt_q;
              if (nxt_q == ST_RD) begin
                txreg_q    <= rd_data[6:0];
                sda_pull_q <= ~rd_data[7];
              end else begin
                sda_pull_q <= 1'b0;
              end
            end
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bitcnt_q <= bitcnt_q + 4'd1;
            if (ack_sample) begin
              ptr_q <= ptr_q + PTR_W'(1);
              if (sda_s) state_q <= ST_IDLE;
            end
          end
          if (scl_fall) begin
            if (bitcnt_q >= 4'd1 && bitcnt_q <= 4'd7) begin
              sda_pull_q <= ~txreg_q[6];
              txreg_q    <= {txreg_q[5:0], 1'b0};
            end else if (bitcnt_q == 4'd8) begin
              sda_pull_q <= 1'b0;
            end else if (bitcnt_q == 4'd9) begin
              bitcnt_q   <= '0;
              txreg_q    <= rd_data[6:0];
              sda_pull_q <= ~rd_data[7];
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_pull_o = sda_pull_q;

  if (STRETCH_EN) begin : g_stretch
    logic scl_pull_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          scl_pull_q <= 1'b0;
      else if (!stall_i || !addressed)     scl_pull_q <= 1'b0;
      else if (!scl_s)                     scl_pull_q <= 1'b1;
    end
    assign scl_pull_o = scl_pull_q;
  end else begin : g_nostretch
    assign scl_pull_o = 1'b0;
  end
endmodule

// File: rtl/i2c_tgt10_chk.sv
module i2c_tgt10_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic in_idle,
  input logic stall_i,
  input logic sda_pull_o,
  input logic scl_pull_o
);
  // R11
  sda_edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pull_o) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s));

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o);

  // R8
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_pull_o);

  // R10
  stall_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(stall_i) |-> !scl_pull_o);

  // R10
  stretch_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_o) |-> !$past(scl_s));

  // R10
  idle_no_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_idle) |-> !scl_pull_o);
endmodule

bind i2c_tgt10 i2c_tgt10_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .in_idle(in_idle), .stall_i(stall_i),
  .sda_pull_o(sda_pull_o), .scl_pull_o(scl_pull_o)
);

// File: tb/i2c_tgt10_tb_top.sv
module i2c_tgt10_tb_top;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_scl_low = 1'b0;
  logic ctl_sda_low = 1'b0;
  logic stall_i = 1'b0;
  logic sda_pull_o, scl_pull_o;
  logic scl_bus, sda_bus;

  int n_checks = 0;
  int n_err = 0;
  int r11_viol = 0;
  bit done = 1'b0;
  logic prev_scl = 1'b1;
  logic prev_pull = 1'b0;

  always #4 clk = ~clk;

  assign scl_bus = ~(ctl_scl_low | scl_pull_o);
  assign sda_bus = ~(ctl_sda_low | sda_pull_o);

  i2c_tgt10 dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .stall_i(stall_i), .sda_pull_o(sda_pull_o), .scl_pull_o(scl_pull_o)
  );

  // R11 monitor: target SDA drive must not move during an SCL high phase
  always @(negedge clk) begin
    if (rst_n && scl_bus && prev_scl && (sda_pull_o != prev_pull)) r11_viol++;
    prev_scl  <= scl_bus;
    prev_pull <= sda_pull_o;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic scl_release();
    ctl_scl_low = 1'b0;
    while (scl_bus !== 1'b1) @(negedge clk);
  endtask

  task automatic bus_start();
    ctl_sda_low = 1'b0; wait_q();
    scl_release();      wait_q();
    ctl_sda_low = 1'b1; wait_q();
    ctl_scl_low = 1'b1; wait_q();
  endtask

  task automatic bus_stop();
    ctl_sda_low = 1'b1; wait_q();
    scl_release();      wait_q();
    ctl_sda_low = 1'b0; wait_q();
  endtask

  task automatic clock_bit(input logic b, output logic s);
    ctl_sda_low = ~b; wait_q();
    scl_release();    wait_q();
    s = sda_bus;      wait_q();
    ctl_scl_low = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(d[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      d[i] = s;
    end
    clock_bit(~give_ack, s);
  endtask

  task automatic tx_expect(input string req, input logic [7:0] d, input logic exp_ack);
    logic a;
    send_byte(d, a);
    check(req, $sformatf("ack of %02h", d), a, exp_ack);
  endtask

  task automatic rx_expect(input string req, input logic give_ack, input logic [7:0] exp);
    logic [7:0] d;
    recv_byte(give_ack, d);
    check(req, "read data", d, exp);
  endtask

  // R1, R6
  task automatic t_reset_read();
    check("R1", "sda pull after reset", sda_pull_o, 1'b0);
    check("R1", "scl pull after reset", scl_pull_o, 1'b0);
    bus_start();
    tx_expect("R2", 8'h55, 1'b1);
    rx_expect("R1", 1'b1, 8'hA0);
    rx_expect("R6", 1'b1, 8'hA1);
    rx_expect("R6", 1'b0, 8'hA2);
    bus_stop();
  endtask

  // R5, R8, R6
  task automatic t_write_wrap();
    bus_start();
    tx_expect("R2", 8'h54, 1'b1);
    tx_expect("R5", 8'h06, 1'b1);
    tx_expect("R5", 8'h11, 1'b1);
    tx_expect("R5", 8'h22, 1'b1);
    tx_expect("R5", 8'h33, 1'b1);
    bus_start();
    tx_expect("R8", 8'h54, 1'b1);
    tx_expect("R8", 8'h06, 1'b1);
    bus_start();
    tx_expect("R8", 8'h55, 1'b1);
    rx_expect("R8", 1'b1, 8'h11);
    rx_expect("R5", 1'b1, 8'h22);
    rx_expect("R5", 1'b0, 8'h33);
    bus_stop();
    check("R9", "sda released after stop", sda_pull_o, 1'b0);
    bus_start();
    tx_expect("R6", 8'h55, 1'b1);
    rx_expect("R6", 1'b0, 8'hA1);
    bus_stop();
  endtask

  // R2
  task automatic t_wrong7();
    bus_start();
    tx_expect("R2", 8'h56, 1'b0);
    tx_expect("R2", 8'h00, 1'b0);
    tx_expect("R2", 8'h99, 1'b0);
    bus_stop();
    bus_start();
    tx_expect("R2", 8'h55, 1'b1);
    rx_expect("R2", 1'b0, 8'hA2);
    bus_stop();
  endtask

  // R3, R4, R8
  task automatic t_ten_write_read();
    bus_start();
    tx_expect("R3", 8'hF4, 1'b1);
    tx_expect("R4", 8'hC5, 1'b1);
    tx_expect("R5", 8'h03, 1'b1);
    tx_expect("R5", 8'h5A, 1'b1);
    bus_start();
    tx_expect("R3", 8'hF4, 1'b1);
    tx_expect("R4", 8'hC5, 1'b1);
    tx_expect("R5", 8'h03, 1'b1);
    bus_start();
    tx_expect("R3", 8'hF5, 1'b1);
    tx_expect("R4", 8'hC5, 1'b1);
    rx_expect("R8", 1'b0, 8'h5A);
    bus_stop();
  endtask

  // R3
  task automatic t_ten_hdr_miss();
    bus_start();
    tx_expect("R3", 8'hF2, 1'b0);
    tx_expect("R3", 8'hC5, 1'b0);
    tx_expect("R3", 8'h00, 1'b0);
    bus_stop();
  endtask

  // R4
  task automatic t_ten_lo_miss();
    bus_start();
    tx_expect("R4", 8'hF4, 1'b1);
    tx_expect("R4", 8'hC4, 1'b0);
    tx_expect("R4", 8'h01, 1'b0);
    bus_stop();
    bus_start();
    tx_expect("R4", 8'h55, 1'b1);
    rx_expect("R4", 1'b0, 8'hA4);
    bus_stop();
  endtask

  // R7
  task automatic t_read_nack();
    logic [7:0] d;
    bus_start();
    tx_expect("R7", 8'h55, 1'b1);
    rx_expect("R7", 1'b0, 8'hA5);
    recv_byte(1'b0, d);
    check("R7", "bus after controller NACK", d, 8'hFF);
    bus_stop();
  endtask

  // R10
  task automatic t_stretch();
    stall_i = 1'b1; wait_q(); wait_q();
    check("R10", "no stretch while idle", scl_pull_o, 1'b0);
    stall_i = 1'b0;
    bus_start();
    tx_expect("R10", 8'h54, 1'b1);
    stall_i = 1'b1; wait_q();
    check("R10", "scl pulled while stalled", scl_pull_o, 1'b1);
    ctl_scl_low = 1'b0; wait_q(); wait_q();
    check("R10", "scl held low by target", scl_bus, 1'b0);
    ctl_scl_low = 1'b1;
    stall_i = 1'b0; wait_q();
    check("R10", "scl released after stall", scl_pull_o, 1'b0);
    tx_expect("R10", 8'h02, 1'b1);
    tx_expect("R10", 8'h77, 1'b1);
    bus_start();
    tx_expect("R10", 8'h54, 1'b1);
    tx_expect("R10", 8'h02, 1'b1);
    bus_start();
    tx_expect("R10", 8'h55, 1'b1);
    rx_expect("R10", 1'b0, 8'h77);
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset_read();
    t_write_wrap();
    t_wrong7();
    t_ten_write_read();
    t_ten_hdr_miss();
    t_ten_lo_miss();
    t_read_nack();
    t_stretch();
    check("R11", "SDA drive moved while SCL high", r11_viol, 0);
    check("R9", "sda released at end", sda_pull_o, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule